// File: doc/BRIEF.md
# Parity-Protected Write-Back Line Store

This block is the data side of a small direct-mapped write-back level-one data cache. Every stored word has its own even-parity bit and its own dirty bit. The core reaches the block through a valid/ready request port, where a request carries a word address, a read/write flag and write data. Read results come back on a separate response strobe. On the memory side the block moves whole lines. A line fill is a read request followed by one data beat. An eviction is a single write carrying the line, the line address and a per-word strobe.

Parity is computed on every store but compared only when a word is read on a hit. If the word in error is clean, memory still holds a good copy. The block then raises an error pulse, writes back any dirty words of that line, refetches the line and returns the refetched word. If the word in error is dirty, no good copy exists. The word is returned as stored, and the error and fatal flags are set with it.

A single-bit fault injection port lets a test flip any stored data bit in place.

Top module: `pwb_cache`

## Requirements
- R1: A word address splits into offset bits [1:0], line index bits [4:2] and tag bits [11:5]. A read or write whose line is not valid or has a different tag fetches the whole line from memory before it is served.
- R2: A read that hits returns its stored word with rd_valid high in the cycle after the request is accepted.
- R3: A write that hits stores the word and marks only that word dirty, with no response. A write that misses first fills the line and then merges the word.
- R4: A write never checks parity. Overwriting a corrupted word leaves it readable without error.
- R5: A read hit whose word fails even parity raises par_err for one cycle, in the cycle after acceptance. A corrupted word does not flag a read of another word in the same line.
- R6: A parity error on a clean word gives par_err without rd_valid. The line's dirty words are then written back, the line is refetched, and rd_valid later returns the memory copy.
- R7: A parity error on a dirty word gives rd_valid, par_err and par_fatal together, with the word as stored.
- R8: An eviction issues one memory write to the victim line address {tag,index}. mem_wstrb bit i is set exactly when word i is dirty, and word i sits at mem_wdata bits [32i+31:32i].
- R9: A line with no dirty words is replaced without any memory write.
- R10: req_ready is low from the acceptance of a miss or a recoverable error until that request is served. A memory request holds its address and kind until mem_ready, and fill data is taken on mem_rvalid.
- R11: flip_en inverts one stored data bit without updating its parity. A core write to the same word in the same cycle takes precedence.
- R12: After reset every line is invalid, req_ready is high and all response and memory strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Word address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| par_err | output | 1 | Parity mismatch seen on a read hit |
| par_fatal | output | 1 | Mismatch was on a dirty word |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory accepts the request |
| mem_write | output | 1 | 1 = write-back, 0 = fill read |
| mem_addr | output | 10 | Line address |
| mem_wdata | output | 128 | Write-back line |
| mem_wstrb | output | 4 | Per-word write enables |
| mem_rvalid | input | 1 | Fill data valid |
| mem_rdata | input | 128 | Fill line |
| flip_en | input | 1 | Inject a bit flip |
| flip_index | input | 3 | Line of the flip |
| flip_word | input | 2 | Word of the flip |
| flip_bit | input | 5 | Bit of the flip |

## Verification
A fault injection and a core write can land on the same word in the same cycle. The bench provokes this by driving flip_en in the very cycle a write to that word is accepted. It then reads the word back and expects clean data with no parity flag, because the write wins. A recoverable parity error can also coincide with dirty neighbours in its line, so one read triggers both a write-back and a refetch. The behavioural model predicts the strobed words and the later response, and compares them as each memory beat and response appears.

// File: rtl/pwb_pkg.sv
// Package: shared controller state encoding for the parity-protected line store.
package pwb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WBACK = 3'd1,
        ST_FREQ  = 3'd2,
        ST_FWAIT = 3'd3,
        ST_SERVE = 3'd4
    } st_t;
endpackage

// File: rtl/pwb_par_chk.sv
// Module: pwb_par_chk
// Recomputes even parity of every word in a line and flags each word whose
// stored parity bit disagrees. Purely combinational; assumes even parity.
module pwb_par_chk #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 4
) (
    input  logic [DATA_W*WORDS-1:0] line,
    input  logic [WORDS-1:0]        par,
    output logic [WORDS-1:0]        bad
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // per-word mismatch between recomputed and stored parity
        assign bad[w] = (^line[w*DATA_W +: DATA_W]) ^ par[w];
    end
endmodule

// File: rtl/pwb_array.sv
// Module: pwb_array
// Storage of data words, per-word parity, per-word dirty, line valid and tag.
// Assumes a fill and a core word write never occur in the same cycle; a
// fault flip may coincide with either, and the later store wins.
module pwb_array #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int LINES  = 8,
    parameter int TAG_W  = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(LINES)-1:0]      idx,
    input  logic                          wr_en,
    input  logic [$clog2(WORDS)-1:0]      wr_off,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          fill_en,
    input  logic [TAG_W-1:0]              fill_tag,
    input  logic [DATA_W*WORDS-1:0]       fill_line,
    input  logic                          flip_en,
    input  logic [$clog2(LINES)-1:0]      flip_idx,
    input  logic [$clog2(WORDS)-1:0]      flip_off,
    input  logic [$clog2(DATA_W)-1:0]     flip_bit,
    output logic                          lk_valid,
    output logic [TAG_W-1:0]              lk_tag,
    output logic [DATA_W*WORDS-1:0]       lk_line,
    output logic [WORDS-1:0]              lk_par,
    output logic [WORDS-1:0]              lk_dirty
);
    logic [DATA_W-1:0] data_q  [LINES][WORDS];
    logic [WORDS-1:0]  par_q   [LINES];
    logic [WORDS-1:0]  dirty_q [LINES];
    logic [TAG_W-1:0]  tag_q   [LINES];
    logic [LINES-1:0]  valid_q;

    // state update: flip, then fill or word write (later assignment wins)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int l = 0; l < LINES; l++) begin
                par_q[l]   <= '0;
                dirty_q[l] <= '0;
                tag_q[l]   <= '0;
                for (int w = 0; w < WORDS; w++) data_q[l][w] <= '0;
            end
        end else begin
            if (flip_en)
                data_q[flip_idx][flip_off][flip_bit] <= ~data_q[flip_idx][flip_off][flip_bit];
            if (fill_en) begin
                for (int w = 0; w < WORDS; w++) begin
                    data_q[idx][w] <= fill_line[w*DATA_W +: DATA_W];
                    par_q[idx][w]  <= ^fill_line[w*DATA_W +: DATA_W];
                end
                dirty_q[idx] <= '0;
                tag_q[idx]   <= fill_tag;
                valid_q[idx] <= 1'b1;
            end
            if (wr_en) begin
                data_q[idx][wr_off]  <= wr_data;
                par_q[idx][wr_off]   <= ^wr_data;
                dirty_q[idx][wr_off] <= 1'b1;
            end
        end
    end

    // lookup of the indexed line
    always_comb begin
        for (int w = 0; w < WORDS; w++) lk_line[w*DATA_W +: DATA_W] = data_q[idx][w];
        lk_valid = valid_q[idx];
        lk_tag   = tag_q[idx];
        lk_par   = par_q[idx];
        lk_dirty = dirty_q[idx];
    end
endmodule

// File: rtl/pwb_ctrl.sv
// Module: pwb_ctrl
// Request acceptance, hit detection, read-hit parity decision and the
// write-back / fill sequencer. Assumes the memory answers each fill request
// with exactly one mem_rvalid beat, and that write-backs need no response.
module pwb_ctrl
    import pwb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int LINES  = 8,
    parameter int ADDR_W = 12,
    parameter int OFF_W  = $clog2(WORDS),
    parameter int IDX_W  = $clog2(LINES),
    parameter int TAG_W  = ADDR_W - OFF_W - IDX_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic                      rd_valid,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      par_err,
    output logic                      par_fatal,
    output logic                      mem_valid,
    input  logic                      mem_ready,
    output logic                      mem_write,
    output logic [TAG_W+IDX_W-1:0]    mem_addr,
    output logic [DATA_W*WORDS-1:0]   mem_wdata,
    output logic [WORDS-1:0]          mem_wstrb,
    input  logic                      mem_rvalid,
    output logic [IDX_W-1:0]          idx,
    output logic                      wr_en,
    output logic [OFF_W-1:0]          wr_off,
    output logic [DATA_W-1:0]         wr_data,
    output logic                      fill_en,
    output logic [TAG_W-1:0]          fill_tag,
    input  logic                      lk_valid,
    input  logic [TAG_W-1:0]          lk_tag,
    input  logic [DATA_W*WORDS-1:0]   lk_line,
    input  logic [WORDS-1:0]          lk_dirty,
    input  logic [WORDS-1:0]          bad
);
    st_t st_q, st_d;
    logic              q_write;
    logic [ADDR_W-1:0] q_addr;
    logic [DATA_W-1:0] q_wdata;
    logic              cur_write;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic [TAG_W-1:0]  cur_tag;
    logic [OFF_W-1:0]  cur_off;
    logic in_idle, go, hit, rd_hit, rd_ok, rd_fatal, retry, evict, need_wb;

    assign in_idle = (st_q == ST_IDLE);
    assign req_ready = in_idle;

    // select the live request in idle, the held one while replaying
    always_comb begin
        cur_write = in_idle ? req_write : q_write;
        cur_addr  = in_idle ? req_addr  : q_addr;
        cur_wdata = in_idle ? req_wdata : q_wdata;
    end

    assign idx     = cur_addr[OFF_W +: IDX_W];
    assign cur_tag = cur_addr[ADDR_W-1 -: TAG_W];
    assign cur_off = cur_addr[OFF_W-1:0];

    // hit and parity decision for the request being served this cycle
    always_comb begin
        go       = (in_idle && req_valid) || (st_q == ST_SERVE);
        hit      = lk_valid && (lk_tag == cur_tag);
        rd_hit   = go && !cur_write && hit;
        rd_ok    = rd_hit && !bad[cur_off];
        rd_fatal = rd_hit && bad[cur_off] && lk_dirty[cur_off];
        retry    = rd_hit && bad[cur_off] && !lk_dirty[cur_off];
        evict    = go && (!hit || retry);
        need_wb  = lk_valid && (|lk_dirty);
    end

    assign wr_en    = go && cur_write && hit;
    assign wr_off   = cur_off;
    assign wr_data  = cur_wdata;
    assign fill_en  = (st_q == ST_FWAIT) && mem_rvalid;
    assign fill_tag = cur_tag;

    // memory port driven from the sequencer state
    always_comb begin
        mem_valid = (st_q == ST_WBACK) || (st_q == ST_FREQ);
        mem_write = (st_q == ST_WBACK);
        mem_addr  = (st_q == ST_WBACK) ? {lk_tag, idx} : {cur_tag, idx};
        mem_wdata = lk_line;
        mem_wstrb = (st_q == ST_WBACK) ? lk_dirty : '0;
    end

    // next sequencer state
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE, ST_SERVE: begin
                if (evict)                 st_d = need_wb ? ST_WBACK : ST_FREQ;
                else if (st_q == ST_SERVE) st_d = ST_IDLE;
            end
            ST_WBACK: if (mem_ready)  st_d = ST_FREQ;
            ST_FREQ:  if (mem_ready)  st_d = ST_FWAIT;
            ST_FWAIT: if (mem_rvalid) st_d = ST_SERVE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // state, held request and registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            q_write   <= 1'b0;
            q_addr    <= '0;
            q_wdata   <= '0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            par_err   <= 1'b0;
            par_fatal <= 1'b0;
        end else begin
            st_q <= st_d;
            if (in_idle && req_valid) begin
                q_write <= req_write;
                q_addr  <= req_addr;
                q_wdata <= req_wdata;
            end
            rd_valid  <= rd_ok || rd_fatal;
            rd_data   <= lk_line[cur_off*DATA_W +: DATA_W];
            par_err   <= rd_fatal || retry;
            par_fatal <= rd_fatal;
        end
    end

    // R10: a memory request waiting for mem_ready keeps address and kind
    a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

    // R10: an accepted fill request is followed by a stalled core port
    a_r10_fill_stall: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready && !mem_write |=> !mem_valid && !req_ready);

    // R9: no write-back is ever issued with an empty strobe
    a_r9_no_empty_wb: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_write |-> mem_wstrb != '0);

    // R7: a fatal error always comes with data and the error flag
    a_r7_fatal_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        par_fatal |-> par_err && rd_valid);

    // R6: a recoverable error returns no data yet and holds the core off
    a_r6_retry_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        par_err && !par_fatal |-> !rd_valid && !req_ready);
endmodule

// File: rtl/pwb_cache.sv
// Module: pwb_cache (top)
// Direct-mapped write-back data store with per-word parity and dirty bits.
// Assumes the memory side never drops a fill request once accepted.
module pwb_cache #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int LINES  = 8,
    parameter int ADDR_W = 12
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          req_valid,
    output logic                                          req_ready,
    input  logic                                          req_write,
    input  logic [ADDR_W-1:0]                             req_addr,
    input  logic [DATA_W-1:0]                             req_wdata,
    output logic                                          rd_valid,
    output logic [DATA_W-1:0]                             rd_data,
    output logic                                          par_err,
    output logic                                          par_fatal,
    output logic                                          mem_valid,
    input  logic                                          mem_ready,
    output logic                                          mem_write,
    output logic [ADDR_W-$clog2(WORDS)-1:0]               mem_addr,
    output logic [DATA_W*WORDS-1:0]                       mem_wdata,
    output logic [WORDS-1:0]                              mem_wstrb,
    input  logic                                          mem_rvalid,
    input  logic [DATA_W*WORDS-1:0]                       mem_rdata,
    input  logic                                          flip_en,
    input  logic [$clog2(LINES)-1:0]                      flip_index,
    input  logic [$clog2(WORDS)-1:0]                      flip_word,
    input  logic [$clog2(DATA_W)-1:0]                     flip_bit
);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_W = DATA_W * WORDS;

    logic [IDX_W-1:0]  idx;
    logic              wr_en, fill_en, lk_valid;
    logic [OFF_W-1:0]  wr_off;
    logic [DATA_W-1:0] wr_data;
    logic [TAG_W-1:0]  fill_tag, lk_tag;
    logic [LINE_W-1:0] lk_line;
    logic [WORDS-1:0]  lk_par, lk_dirty, bad;

    pwb_array #(.DATA_W(DATA_W), .WORDS(WORDS), .LINES(LINES), .TAG_W(TAG_W)) u_array (
        .clk(clk), .rst_n(rst_n), .idx(idx),
        .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
        .fill_en(fill_en), .fill_tag(fill_tag), .fill_line(mem_rdata),
        .flip_en(flip_en), .flip_idx(flip_index), .flip_off(flip_word), .flip_bit(flip_bit),
        .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_line(lk_line),
        .lk_par(lk_par), .lk_dirty(lk_dirty)
    );

    pwb_par_chk #(.DATA_W(DATA_W), .WORDS(WORDS)) u_chk (
        .line(lk_line), .par(lk_par), .bad(bad)
    );

    pwb_ctrl #(.DATA_W(DATA_W), .WORDS(WORDS), .LINES(LINES), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .par_err(par_err), .par_fatal(par_fatal),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
        .mem_rvalid(mem_rvalid),
        .idx(idx), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
        .fill_en(fill_en), .fill_tag(fill_tag),
        .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_line(lk_line),
        .lk_dirty(lk_dirty), .bad(bad)
    );
endmodule

// File: tb/sim_pwb_cache.sv
`timescale 1ns/1ps
module sim_pwb_cache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_write = 1'b0;
    logic [11:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         req_ready, rd_valid, par_err, par_fatal;
    logic [31:0]  rd_data;
    logic         mem_valid, mem_write;
    logic         mem_ready = 1'b0, mem_rvalid = 1'b0;
    logic [9:0]   mem_addr;
    logic [127:0] mem_wdata, mem_rdata = '0;
    logic [3:0]   mem_wstrb;
    logic         flip_en = 1'b0;
    logic [2:0]   flip_index = '0;
    logic [1:0]   flip_word = '0;
    logic [4:0]   flip_bit = '0;

    always #4 clk = ~clk;

    pwb_cache u0 (.*);

    typedef struct packed { logic v; logic e; logic f; logic [31:0] d; } rsp_t;
    typedef struct packed { logic [9:0] a; logic [3:0] s; logic [127:0] d; } wb_t;
    rsp_t rq[$];
    wb_t  wq[$];

    // reference model: cache image and memory image
    logic [31:0] mdata [8][4];
    logic [3:0]  mdirty [8], mcorr [8];
    logic        mv [8];
    logic [6:0]  mt [8];
    logic [31:0] mimg [4096];
    logic [31:0] smem [4096];

    int n_chk = 0, n_err = 0, n_wr = 0;
    bit done = 1'b0;

    function automatic logic [31:0] seed_word(int a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [11:0] mk(int tag, int ix, int off);
        return {tag[6:0], ix[2:0], off[1:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic m_evict(input int ix);
        wb_t w;
        if (mv[ix] && (|mdirty[ix])) begin
            w.a = {mt[ix], ix[2:0]};
            w.s = mdirty[ix];
            w.d = '0;
            for (int k = 0; k < 4; k++)
                if (mdirty[ix][k]) begin
                    w.d[k*32 +: 32] = mdata[ix][k];
                    mimg[{w.a, 2'(k)}] = mdata[ix][k];
                end
            wq.push_back(w);
        end
    endtask

    task automatic m_fill(input int ix, input logic [6:0] tg);
        for (int k = 0; k < 4; k++) mdata[ix][k] = mimg[{tg, ix[2:0], 2'(k)}];
        mdirty[ix] = '0;
        mcorr[ix]  = '0;
        mv[ix]     = 1'b1;
        mt[ix]     = tg;
    endtask

    task automatic m_access(input bit wr, input logic [11:0] a, input logic [31:0] d);
        int ix, off;
        logic [6:0] tg;
        bit hit;
        ix  = int'(a[4:2]);
        off = int'(a[1:0]);
        tg  = a[11:5];
        hit = mv[ix] && (mt[ix] == tg);
        if (!wr && hit && mcorr[ix][off]) begin
            if (mdirty[ix][off]) begin
                rq.push_back('{1'b1, 1'b1, 1'b1, mdata[ix][off]});
                return;
            end
            rq.push_back('{1'b0, 1'b1, 1'b0, 32'h0});
            m_evict(ix);
            m_fill(ix, tg);
            rq.push_back('{1'b1, 1'b0, 1'b0, mdata[ix][off]});
            return;
        end
        if (!hit) begin
            m_evict(ix);
            m_fill(ix, tg);
        end
        if (wr) begin
            mdata[ix][off]  = d;
            mdirty[ix][off] = 1'b1;
            mcorr[ix][off]  = 1'b0;
        end else begin
            rq.push_back('{1'b1, 1'b0, 1'b0, mdata[ix][off]});
        end
    endtask

    task automatic m_flip(input int ix, input int off, input int b);
        mdata[ix][off] = mdata[ix][off] ^ (32'h1 << b);
        mcorr[ix][off] = ~mcorr[ix][off];
    endtask

    // issue one request (optionally with a same-cycle flip); starts and ends at a negedge
    task automatic do_req(input bit wr, input logic [11:0] a, input logic [31:0] d,
                          input bit fl = 1'b0, input int fi = 0, input int fo = 0, input int fb = 0);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        if (fl) begin
            flip_en = 1'b1; flip_index = 3'(fi); flip_word = 2'(fo); flip_bit = 5'(fb);
            m_flip(fi, fo, fb);
        end
        m_access(wr, a, d);
        @(negedge clk);
        req_valid = 1'b0;
        flip_en   = 1'b0;
    endtask

    task automatic do_flip(input int fi, input int fo, input int fb);
        while (!req_ready) @(negedge clk);
        flip_en = 1'b1; flip_index = 3'(fi); flip_word = 2'(fo); flip_bit = 5'(fb);
        m_flip(fi, fo, fb);
        @(negedge clk);
        flip_en = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while ((rq.size() != 0 || wq.size() != 0 || !req_ready) && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    // memory slave and per-cycle comparison against the model queues
    initial begin
        int cnt = 0;
        logic [9:0] pend = '0;
        logic [15:0] lf = 16'hACE1;
        rsp_t e;
        wb_t  w;
        for (int i = 0; i < 4096; i++) begin
            mimg[i] = seed_word(i);
            smem[i] = seed_word(i);
        end
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (rd_valid || par_err) begin
                    if (rq.size() == 0) begin
                        chk(1'b0, "R2 unexpected response", {rd_valid, par_err, par_fatal, rd_data}, 0);
                    end else begin
                        e = rq.pop_front();
                        chk({rd_valid, par_err, par_fatal} == {e.v, e.e, e.f},
                            e.f ? "R7 flags" : (e.e ? "R5 R6 flags" : "R2 flags"),
                            {rd_valid, par_err, par_fatal}, {e.v, e.e, e.f});
                        if (e.v)
                            chk(rd_data == e.d, e.f ? "R7 data" : "R1 R2 R6 data", rd_data, e.d);
                    end
                end
                if (mem_valid) chk(!req_ready, "R10 stall during memory traffic", req_ready, 0);
            end
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            mem_ready = lf[0] | lf[3];
            if (mem_rvalid) mem_rvalid = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    for (int k = 0; k < 4; k++) mem_rdata[k*32 +: 32] = smem[{pend, 2'(k)}];
                    mem_rvalid = 1'b1;
                end
            end
            if (rst_n && mem_valid && mem_ready) begin
                if (mem_write) begin
                    n_wr++;
                    if (wq.size() == 0) begin
                        chk(1'b0, "R9 unexpected write-back", {mem_addr, mem_wstrb}, 0);
                    end else begin
                        w = wq.pop_front();
                        chk({mem_addr, mem_wstrb} == {w.a, w.s}, "R8 address and strobes",
                            {mem_addr, mem_wstrb}, {w.a, w.s});
                        for (int k = 0; k < 4; k++)
                            if (w.s[k]) chk(mem_wdata[k*32 +: 32] == w.d[k*32 +: 32], "R8 data",
                                            mem_wdata[k*32 +: 32], w.d[k*32 +: 32]);
                    end
                    for (int k = 0; k < 4; k++)
                        if (mem_wstrb[k]) smem[{mem_addr, 2'(k)}] = mem_wdata[k*32 +: 32];
                end else begin
                    pend = mem_addr;
                    cnt  = 2;
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int wr0;
        for (int l = 0; l < 8; l++) begin
            mv[l] = 1'b0; mt[l] = '0; mdirty[l] = '0; mcorr[l] = '0;
            for (int k = 0; k < 4; k++) mdata[l][k] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: state after reset
        chk(req_ready === 1'b1, "R12 ready", req_ready, 1);
        chk({rd_valid, par_err, par_fatal, mem_valid} === 4'b0, "R12 strobes",
            {rd_valid, par_err, par_fatal, mem_valid}, 0);

        // R1 miss fill, R2 hit
        do_req(1'b0, mk(1, 0, 0), 0);
        do_req(1'b0, mk(1, 0, 3), 0);
        // R3 write hits on words 1 and 2, read back
        do_req(1'b1, mk(1, 0, 1), 32'hAAAA_0001);
        do_req(1'b1, mk(1, 0, 2), 32'hBBBB_0002);
        do_req(1'b0, mk(1, 0, 1), 0);
        // R8 conflict eviction writes back only words 1 and 2
        do_req(1'b0, mk(2, 0, 0), 0);
        drain();
        // R9 clean eviction: no memory write at all
        do_req(1'b0, mk(1, 1, 0), 0);
        drain();
        wr0 = n_wr;
        do_req(1'b0, mk(3, 1, 0), 0);
        drain();
        chk(n_wr == wr0, "R9 clean line dropped", n_wr, wr0);

        // R5 per-word: corrupt word 1, read word 2 -> clean; R6 recover word 1
        do_flip(0, 1, 5);
        do_req(1'b0, mk(2, 0, 2), 0);
        do_req(1'b0, mk(2, 0, 1), 0);
        drain();
        // R7 dirty corrupted word is fatal
        do_req(1'b1, mk(2, 0, 3), 32'hC0DE_0003);
        do_flip(0, 3, 0);
        do_req(1'b0, mk(2, 0, 3), 0);
        drain();
        // R4 write over a corrupted word clears the error
        do_flip(0, 0, 7);
        do_req(1'b1, mk(2, 0, 0), 32'hD00D_0000);
        do_req(1'b0, mk(2, 0, 0), 0);
        // R11 flip and write on the same word in the same cycle: write wins
        do_req(1'b1, mk(2, 0, 2), 32'hEEEE_0002, 1'b1, 0, 2, 9);
        do_req(1'b0, mk(2, 0, 2), 0);
        drain();
        // R6 with dirty neighbours: write-back then refetch
        do_flip(0, 1, 30);
        do_req(1'b0, mk(2, 0, 1), 0);
        drain();
        // R3 write miss merges after fill
        do_req(1'b1, mk(5, 4, 1), 32'h1234_5678);
        do_req(1'b0, mk(5, 4, 1), 0);
        do_req(1'b0, mk(5, 4, 0), 0);
        // R11 double flip restores the word
        do_flip(4, 0, 3);
        do_flip(4, 0, 3);
        do_req(1'b0, mk(5, 4, 0), 0);
        drain();

        // mixed traffic with occasional faults
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom % 16);
            if (r == 0) do_flip(int'($urandom % 8), int'($urandom % 4), int'($urandom % 32));
            else do_req(r < 6, mk(int'($urandom % 4), int'($urandom % 8), int'($urandom % 4)), $urandom);
        end
        drain();
        chk(rq.size() == 0, "R2 all responses seen", rq.size(), 0);
        chk(wq.size() == 0, "R8 all write-backs seen", wq.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule